// File: doc/BRIEF.md
# TDM Playback Frame Receiver

This block receives a time-division-multiplexed serial audio stream on a single data line and turns each frame into eight parallel sample words. It runs directly on the bit clock, with every input sampled on the rising edge. A frame-sync pulse at the sample rate marks where each frame begins. A frame is 256 bit clocks long and is split into eight 32-bit slots, which carry channels 1 to 8 in that order.

Each slot holds one sample, left-justified and sent MSB first. A two-bit length code sets how many leading bits of each slot are kept: 16, 18, 20 or 24. All bits after that length are dropped. The kept bits are placed at the top of a 24-bit output word and the bits below are filled with zeros. The block updates all eight words in the same cycle and raises a one-cycle done strobe at that moment. It also checks that each frame sync arrives exactly one frame after the previous one.

Top module: `tdm_frame_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every sample word, `frame_done` and `frame_err` are 0.
- R2: The receiver looks for a rising edge of `fsync` as seen at two successive rising clock edges: low at one edge, high at the next. That second edge is the sync edge. The rising clock edge right after the sync edge captures the MSB of slot 1 as frame bit 0. The sync edge itself also restarts the bit count.
- R3: Frame bits 32*k to 32*k+31 make up slot k+1 (k = 0..7), MSB first. The sample of slot k+1 appears on `samples[24*k+23:24*k]`.
- R4: `word_len` selects how many bits are kept: 0 keeps 16, 1 keeps 18, 2 keeps 20, 3 keeps 24. Only the first L bits of each slot are kept. The remaining bits of the slot have no effect on the output.
- R5: Each output word holds the kept bits in bits [23:24-L], with the first received bit in bit 23. Bits [23-L:0] are zero.
- R6: `frame_done` is high for exactly one cycle, in the cycle after the edge that captures frame bit 255. All eight words change only in that cycle and hold their values at all other times.
- R7: Until the first sync edge after reset, no data is captured and `frame_done` stays low.
- R8: A sync edge at any bit other than frame bit 255 (i.e. not 256 bits after the previous sync) sets `frame_err`. The flag stays set until reset. The count restarts, so the bit after that edge is bit 0 of slot 1.
- R9: If `fsync` stays high for several bit clocks, only its rising edge counts. The held level neither restarts the count nor raises `frame_err`.
- R10: A sync edge that falls on frame bit 255 leaves `frame_err` unchanged. Back-to-back correct frames never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync, rising once per frame |
| sdata | input | 1 | Serial sample data, MSB first |
| word_len | input | 2 | Valid length code: 0=16, 1=18, 2=20, 3=24 bits |
| samples | output | 192 | Eight 24-bit words, slot k+1 at bits [24k+23:24k] |
| frame_done | output | 1 | One-cycle strobe when all eight words update |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The checker module checks the timing rules on every cycle:
- `frame_done` follows only the capture of bit 255, and never lasts two cycles.
- The sample words hold their value whenever `frame_done` is low.
- A misplaced sync edge always sets `frame_err`, and `frame_err` never clears.
- Every sync edge restarts the count at bit 0.

Some behaviours can only be shown by the bench's frames, because checking them needs the whole transmitted bit pattern:
- the slot-to-channel order;
- the effect of each length code on the kept bits and the zero fill;
- that a held sync level is ignored;
- that data lines up again correctly after a misplaced sync.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned SLOTS     = 8;
  localparam int unsigned SLOT_BITS = 32;
  localparam int unsigned WORD_W    = 24;

  // Length code to number of kept bits (16/18/20/24).
  function automatic int unsigned kept_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // True when slot bit position pos is inside the kept length.
  function automatic logic bit_kept(input int unsigned pos, input logic [1:0] code);
    return pos < kept_bits(code);
  endfunction
endpackage

// File: rtl/tdm_sync_tracker.sv
module tdm_sync_tracker #(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             sync_hit,
  output logic             sync_err,
  output logic             locked,
  output logic [CNT_W-1:0] bit_idx,
  output logic             frame_last,
  output logic             frame_err
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic fsync_q;

  assign sync_hit   = fsync & ~fsync_q;
  assign sync_err   = sync_hit & locked & (bit_idx != LAST);
  assign frame_last = locked & (bit_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsync_q   <= 1'b0;
      locked    <= 1'b0;
      bit_idx   <= '0;
      frame_err <= 1'b0;
    end else begin
      fsync_q <= fsync;
      if (sync_err) frame_err <= 1'b1;
      if (sync_hit) begin
        locked  <= 1'b1;
        bit_idx <= '0;
      end else if (locked) begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_shifter.sv
module tdm_slot_shifter
  import tdm_rx_pkg::*;
#(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned WORD_B = 24,
  localparam int unsigned POS_W = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [POS_W-1:0]  pos,
  input  logic [1:0]        word_len,
  input  logic              sdata,
  output logic [WORD_B-1:0] acc_next
);
  logic [WORD_B-1:0] acc;
  int idx;

  always_comb begin
    acc_next = (pos == '0) ? '0 : acc;
    idx = int'(WORD_B) - 1 - int'(pos);
    if (bit_kept(int'(pos), word_len) && idx >= 0) acc_next[idx] = sdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= acc_next;
  end
endmodule

// File: rtl/tdm_frame_store.sv
module tdm_frame_store #(
  parameter int unsigned NSLOT  = 8,
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned WORD_B = 24,
  localparam int unsigned POS_W = $clog2(SLOT_W),
  localparam int unsigned SEL_W = $clog2(NSLOT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [SEL_W-1:0]        slot,
  input  logic [POS_W-1:0]        pos,
  input  logic [WORD_B-1:0]       acc_next,
  input  logic                    frame_last,
  output logic [NSLOT*WORD_B-1:0] samples,
  output logic                    frame_done
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_W - 1);

  logic slot_end;
  assign slot_end = en & (pos == POS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) frame_done <= 1'b0;
    else        frame_done <= frame_last;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_word
    if (k < NSLOT - 1) begin : g_staged
      logic [WORD_B-1:0] stage;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage <= '0;
          samples[k*WORD_B +: WORD_B] <= '0;
        end else begin
          if (slot_end && slot == SEL_W'(k)) stage <= acc_next;
          if (frame_last) samples[k*WORD_B +: WORD_B] <= stage;
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (!rst_n)          samples[k*WORD_B +: WORD_B] <= '0;
        else if (frame_last) samples[k*WORD_B +: WORD_B] <= acc_next;
      end
    end
  end
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
  import tdm_rx_pkg::*;
#(
  parameter int unsigned NSLOT  = SLOTS,
  parameter int unsigned SLOT_W = SLOT_BITS,
  parameter int unsigned WORD_B = WORD_W,
  localparam int unsigned FRAME_BITS = NSLOT * SLOT_W,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS),
  localparam int unsigned POS_W = $clog2(SLOT_W),
  localparam int unsigned SEL_W = $clog2(NSLOT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fsync,
  input  logic                    sdata,
  input  logic [1:0]              word_len,
  output logic [NSLOT*WORD_B-1:0] samples,
  output logic                    frame_done,
  output logic                    frame_err
);
  logic             sync_hit, sync_err, locked, frame_last;
  logic [CNT_W-1:0] bit_idx;
  logic [WORD_B-1:0] acc_next;
  logic [POS_W-1:0] pos;
  logic [SEL_W-1:0] slot;

  assign pos  = bit_idx[POS_W-1:0];
  assign slot = bit_idx[CNT_W-1:POS_W];

  tdm_sync_tracker #(.FRAME_BITS(FRAME_BITS)) u_sync (
    .clk, .rst_n, .fsync, .sync_hit, .sync_err, .locked,
    .bit_idx, .frame_last, .frame_err
  );

  tdm_slot_shifter #(.SLOT_W(SLOT_W), .WORD_B(WORD_B)) u_shift (
    .clk, .rst_n, .en(locked), .pos, .word_len, .sdata, .acc_next
  );

  tdm_frame_store #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .WORD_B(WORD_B)) u_store (
    .clk, .rst_n, .en(locked), .slot, .pos, .acc_next,
    .frame_last, .samples, .frame_done
  );
endmodule

// File: rtl/tdm_frame_rx_chk.sv
module tdm_frame_rx_chk #(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned WORD_B = 24,
  parameter int unsigned CNT_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sync_hit,
  input logic                    sync_err,
  input logic                    locked,
  input logic [CNT_W-1:0]        bit_idx,
  input logic                    frame_last,
  input logic                    frame_done,
  input logic                    frame_err,
  input logic [NSLOT*WORD_B-1:0] samples
);
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> frame_done);
  a_r6_done_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(frame_last));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r6_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(samples));
  a_r7_no_done_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !frame_done);
  a_r8_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> frame_err);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> (locked && bit_idx == '0));
endmodule

bind tdm_frame_rx tdm_frame_rx_chk #(.NSLOT(NSLOT), .WORD_B(WORD_B), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_hit(sync_hit), .sync_err(sync_err),
  .locked(locked), .bit_idx(bit_idx), .frame_last(frame_last),
  .frame_done(frame_done), .frame_err(frame_err), .samples(samples)
);

// File: tb/tdm_frame_rx_bench.sv
module tdm_frame_rx_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fsync = 1'b0;
  logic         sdata = 1'b0;
  logic [1:0]   word_len = 2'd0;
  logic [191:0] samples;
  logic         frame_done, frame_err;

  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tdm_frame_rx u_tdm_frame_rx (.*);

  always @(negedge clk) if (frame_done) done_cnt++;

  // {length code[35:34], sync hold[33:32], seed[31:0]}
  localparam logic [35:0] VEC [6] = '{
    {2'd0, 2'd1, 32'hA5A5_F00F},
    {2'd1, 2'd1, 32'h1234_5678},
    {2'd2, 2'd2, 32'hDEAD_BEEF},
    {2'd3, 2'd1, 32'h0F0F_3C3C},
    {2'd3, 2'd3, 32'hFFFF_FFFF},
    {2'd0, 2'd1, 32'h8000_0001}
  };

  logic [31:0] slot_data [8];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] make_slot(input logic [31:0] seed, input int k);
    logic [31:0] v;
    v = seed ^ (32'h9E37_79B9 * (k + 1));
    return {v[7:0], v[31:8]} ^ (k[0] ? 32'h5555_5555 : 32'h0);
  endfunction

  function automatic logic [23:0] expect_word(input logic [31:0] s, input logic [1:0] code);
    int L;
    logic [23:0] keep_mask;
    L = (code == 2'd3) ? 24 : 16 + 2 * int'(code);
    keep_mask = ~((24'h1 << (24 - L)) - 24'h1);
    return s[31:8] & keep_mask;
  endfunction

  task automatic drive_bits(input int n, input bit sync_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fsync = sync_last && (i == n - 1);
      sdata = ((i * 7) % 3) == 1;
    end
  endtask

  // One frame; hold = bits fsync stays high (counting the sync bit of the previous frame)
  task automatic run_frame(input logic [1:0] code, input int hold, input bit next_sync, input string tag);
    word_len = code;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      fsync = (i < hold - 1) || (next_sync && i == 255);
      sdata = slot_data[i / 32][31 - (i % 32)];
      if (i == 128) check(frame_done == 1'b0, {tag, " R6 no strobe mid-frame"}, 64'(frame_done), 64'd0);
    end
    @(posedge clk);
    #1;
    check(frame_done == 1'b1, {tag, " R6 strobe after bit 255"}, 64'(frame_done), 64'd1);
    for (int k = 0; k < 8; k++) begin
      logic [23:0] exp_w;
      exp_w = expect_word(slot_data[k], code);
      check(samples[24*k +: 24] == exp_w, $sformatf("%s R3 R4 R5 slot %0d", tag, k + 1),
            64'(samples[24*k +: 24]), 64'(exp_w));
    end
  endtask

  task automatic fill(input logic [31:0] seed);
    for (int k = 0; k < 8; k++) slot_data[k] = make_slot(seed, k);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(samples == '0 && !frame_done && !frame_err, "R1 reset state",
          64'(samples[63:0]) | 64'(frame_done) | 64'(frame_err), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(samples == '0 && !frame_done && !frame_err, "R1 first cycle out of reset",
          64'(samples[63:0]), 64'd0);

    // R7: idle stream with no sync
    drive_bits(300, 1'b0);
    check(done_cnt == 0 && samples == '0, "R7 no capture before sync", 64'(done_cnt), 64'd0);

    // lock: R2 sync edge
    drive_bits(10, 1'b1);

    // table of frames (R2, R3, R4, R5, R6, R9)
    for (int v = 0; v < 6; v++) begin
      fill(VEC[v][31:0]);
      run_frame(VEC[v][35:34], int'(VEC[v][33:32]), 1'b1, $sformatf("vec%0d", v));
    end
    check(frame_err == 1'b0, "R10 R9 correct frames and held sync give no error", 64'(frame_err), 64'd0);

    // R8: misplaced sync
    fill(32'h3333_CCCC);
    run_frame(2'd3, 1, 1'b0, "pre-err");
    drive_bits(101, 1'b1);
    @(posedge clk);
    #1;
    check(frame_err == 1'b1, "R8 misplaced sync flags error", 64'(frame_err), 64'd1);
    fill(32'h7654_3210);
    run_frame(2'd2, 1, 1'b1, "R8 restart");
    fill(32'h0BAD_F00D);
    run_frame(2'd1, 1, 1'b1, "post-err");
    check(frame_err == 1'b1, "R8 error flag sticky", 64'(frame_err), 64'd1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule